// File: doc/BRIEF.md
# Watchdog Clock Source Selector and Divider

This block produces the clock that drives a watchdog timer. It selects one of three free-running inputs: an on-chip RC clock, the main system clock or a dedicated watchdog oscillator. It then divides the chosen clock by an 8-bit integer. Software programs it through three word registers on a simple register bus. The bus has write enable, read enable, a byte offset and 32-bit data, and it is clocked by the bus clock.

A newly written source code does not take effect by itself. The switch is armed only when the update register's enable bit goes from 0 to 1 through two writes. The handover is glitch-free. The old clock is released on its own falling edge. The new clock is enabled on its own falling edge, after a two-flop synchroniser and only once the old one is released. Both clocks must be running during the handover. A divider value of zero stops the output. A new divider value is loaded only at the end of the current output period.

Top module: `wdt_clkgen`

## Requirements
- R1: After reset, all three registers read 0 (once the status bit has settled), the RC clock is the active source and the output clock is held low.
- R2: The register at offset 0x0 holds the source code in bits 1:0: 0 = RC clock, 1 = main clock, 2 = watchdog oscillator, 3 = reserved. It reads back the written value.
- R3: Writing the source code without an update sequence leaves the active source unchanged.
- R4: The register at offset 0x4 holds the enable in bit 0. A switch to the stored code starts only when this bit is written 1 while it holds 0. Writing 1 while it is already 1 has no effect.
- R5: An update with code 3 stored leaves the previously active source in use.
- R6: Bits above the defined fields read 0 and ignore writes. A read at offset 0xC returns 0. The divider register sits at offset 0x8.
- R7: Bit 1 of the register at offset 0x4 is read-only. It reads 1 while a source switch is still in progress and 0 once the new source drives the output.
- R8: A divider value of 0 holds the output clock low with no edges.
- R9: A divider value N from 2 to 255 gives an output period of N source cycles, with the output high for floor(N/2) source cycles.
- R10: A divider value of 1 passes the selected clock through unchanged.
- R11: A new divider value takes effect only at an output period boundary.
- R12: At most one source is enabled onto the output at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irc_clk_i | input | 1 | On-chip RC clock |
| main_clk_i | input | 1 | Main system clock |
| wdo_clk_i | input | 1 | Watchdog oscillator clock |
| we_i | input | 1 | Register write enable |
| re_i | input | 1 | Register read enable |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid one bus cycle after re_i |
| wdt_clk_o | output | 1 | Divided watchdog clock |

## Verification
Read data is registered, so the bench drives a read on a falling bus edge and samples rdata_o on the next falling edge. A switch completes a few source cycles after the update write, plus two bus cycles for the status bit to return. The bench therefore polls the status bit until it clears, and only then measures the output. A new divider value waits for the end of the running period, so the bench discards the first two output periods and times the third, edge to edge. It checks that period and its high time against the source period times N and floor(N/2). For the stopped case, it counts output edges over a fixed window.

// File: rtl/wdt_clkgen_pkg.sv
`timescale 1ns/1ps
package wdt_clkgen_pkg;
  localparam int unsigned NUM_SRC = 3;
  localparam int unsigned DIV_W   = 8;
  localparam logic [1:0]  OFS_SEL = 2'd0;
  localparam logic [1:0]  OFS_UPD = 2'd1;
  localparam logic [1:0]  OFS_DIV = 2'd2;

  typedef enum logic [1:0] {
    SRC_IRC  = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_WDO  = 2'd2,
    SRC_RSVD = 2'd3
  } src_e;
endpackage

// File: rtl/wdt_clkgen_regs.sv
`timescale 1ns/1ps
module wdt_clkgen_regs
  import wdt_clkgen_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic                 re_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NUM_SRC-1:0]   en_src_i,
  output logic [NUM_SRC-1:0]   tgt_o,
  output logic [DIV_W-1:0]     div_o
);
  src_e               sel_q;
  logic               upd_q;
  logic [DIV_W-1:0]   div_q;
  logic [NUM_SRC-1:0] tgt_q;
  logic [NUM_SRC-1:0] en_s1_q, en_s2_q;
  logic               upd_stb, pending;
  logic [1:0]         ofs;
  logic               unused_bits;

  assign ofs         = addr_i[3:2];
  assign unused_bits = ^{wdata_i[31:DIV_W], addr_i[1:0]};
  // arm only on 0 -> 1 of the enable bit
  assign upd_stb = we_i && (ofs == OFS_UPD) && wdata_i[0] && !upd_q;
  assign pending = (en_s2_q != tgt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= SRC_IRC;
      upd_q <= 1'b0;
      div_q <= '0;
    end else if (we_i) begin
      case (ofs)
        OFS_SEL: sel_q <= src_e'(wdata_i[1:0]);
        OFS_UPD: upd_q <= wdata_i[0];
        OFS_DIV: div_q <= wdata_i[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tgt_q <= NUM_SRC'(1);
    else if (upd_stb && sel_q != SRC_RSVD) tgt_q <= NUM_SRC'(1) << sel_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_s1_q <= '0;
      en_s2_q <= '0;
    end else begin
      en_s1_q <= en_src_i;
      en_s2_q <= en_s1_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (re_i) begin
      case (ofs)
        OFS_SEL: rdata_o <= {30'd0, sel_q};
        OFS_UPD: rdata_o <= {30'd0, pending, upd_q};
        OFS_DIV: rdata_o <= {{(32-DIV_W){1'b0}}, div_q};
        default: rdata_o <= '0;
      endcase
    end
  end

  assign tgt_o = tgt_q;
  assign div_o = div_q;

  p_tgt_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(tgt_q));
  p_sel_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_stb |=> $stable(tgt_q));
  p_rsvd_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_stb && sel_q == SRC_RSVD) |=> $stable(tgt_q));
  p_upper_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(re_i) |-> (rdata_o[31:DIV_W] == '0));
endmodule

// File: rtl/wdt_clk_mux.sv
`timescale 1ns/1ps
module wdt_clk_mux #(
  parameter int unsigned N = 3
) (
  input  logic         rst_ni,
  input  logic         chk_clk_i,
  input  logic [N-1:0] clks_i,
  input  logic [N-1:0] tgt_i,
  output logic [N-1:0] en_o,
  output logic         clk_o
);
  logic [N-1:0] en_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    logic s1_q, s2_q, en_bit_q, want;
    logic [N-1:0] others;
    assign others = en_q & ~(N'(1) << i);
    // wait for every other branch to release before asking
    assign want = tgt_i[i] && (others == '0);

    always_ff @(posedge clks_i[i] or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= want;
        s2_q <= s1_q;
      end
    end

    // enable moves only while its clock is low
    always_ff @(negedge clks_i[i] or negedge rst_ni) begin
      if (!rst_ni) en_bit_q <= 1'b0;
      else         en_bit_q <= s2_q;
    end

    assign en_q[i] = en_bit_q;
  end

  assign clk_o = |(clks_i & en_q);
  assign en_o  = en_q;

  p_one_src_r12: assert property (@(posedge chk_clk_i) disable iff (!rst_ni)
    $onehot0(en_q));
endmodule

// File: rtl/wdt_clk_div.sv
`timescale 1ns/1ps
module wdt_clk_div #(
  parameter int unsigned W = 8
) (
  input  logic         rst_ni,
  input  logic         clk_i,
  input  logic [W-1:0] div_i,
  output logic         clk_o
);
  logic [W-1:0] cnt_q, n_q, half;
  logic         out_q, boundary, pass;

  assign half     = n_q >> 1;
  assign boundary = (n_q <= W'(1)) || (cnt_q == n_q - W'(1));
  assign pass     = (n_q == W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      n_q   <= '0;
      out_q <= 1'b0;
    end else if (boundary) begin
      cnt_q <= '0;
      n_q   <= div_i;
      out_q <= (div_i >= W'(2));
    end else begin
      cnt_q <= cnt_q + W'(1);
      out_q <= ((cnt_q + W'(1)) < half);
    end
  end

  assign clk_o = pass ? clk_i : out_q;

  p_reload_edge_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_q != $past(n_q)) |-> $past(boundary));
  p_off_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_q == '0 && div_i == '0) |=> !out_q);
  p_cnt_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_q >= W'(2)) |-> (cnt_q < n_q));
endmodule

// File: rtl/wdt_clkgen.sv
`timescale 1ns/1ps
module wdt_clkgen
  import wdt_clkgen_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irc_clk_i,
  input  logic              main_clk_i,
  input  logic              wdo_clk_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              wdt_clk_o
);
  logic [NUM_SRC-1:0] tgt, en_src, clks;
  logic [DIV_W-1:0]   div;
  logic               mux_clk;

  assign clks = {wdo_clk_i, main_clk_i, irc_clk_i};

  wdt_clkgen_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .re_i     (re_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .en_src_i (en_src),
    .tgt_o    (tgt),
    .div_o    (div)
  );

  wdt_clk_mux #(.N(NUM_SRC)) u_mux (
    .rst_ni    (rst_ni),
    .chk_clk_i (clk_i),
    .clks_i    (clks),
    .tgt_i     (tgt),
    .en_o      (en_src),
    .clk_o     (mux_clk)
  );

  wdt_clk_div #(.W(DIV_W)) u_div (
    .rst_ni (rst_ni),
    .clk_i  (mux_clk),
    .div_i  (div),
    .clk_o  (wdt_clk_o)
  );
endmodule

// File: tb/tb_wdt_clkgen.sv
`timescale 1ns/1ps
module tb_wdt_clkgen;
  localparam real P_BUS = 5.0, P_IRC = 12.0, P_MAIN = 8.0, P_WDO = 20.0;

  logic clk = 0, irc = 0, mainc = 0, wdo = 0, rst_n = 0;
  logic we = 0, re = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        wclk;
  int errors = 0, checks = 0;
  int edges = 0;
  bit done = 0;

  always #(P_BUS/2)  clk   = ~clk;
  always #(P_IRC/2)  irc   = ~irc;
  always #(P_MAIN/2) mainc = ~mainc;
  always #(P_WDO/2)  wdo   = ~wdo;
  always @(posedge wclk) edges++;

  wdt_clkgen dut (
    .clk_i(clk), .rst_ni(rst_n), .irc_clk_i(irc), .main_clk_i(mainc),
    .wdo_clk_i(wdo), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .wdt_clk_o(wclk)
  );

  function automatic real src_period(int s);
    return (s == 0) ? P_IRC : (s == 1) ? P_MAIN : P_WDO;
  endfunction
  function automatic real exp_high(int s, int n);
    return (n == 1) ? src_period(s) / 2.0 : real'(n / 2) * src_period(s);
  endfunction

  task automatic chk_i(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask
  task automatic chk_r(string req, real act, real exp);
    checks++;
    if (act < exp - 0.01 || act > exp + 0.01) begin
      errors++;
      $display("FAIL %s: actual=%0.3f expected=%0.3f", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask
  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); re = 1; addr = a;
    @(negedge clk); d = rdata; re = 0;
  endtask
  task automatic wait_switch();
    logic [31:0] d;
    for (int k = 0; k < 200; k++) begin
      rd(4'h4, d);
      if (!d[1]) break;
    end
  endtask
  task automatic measure(output real per, output real hi);
    realtime t0, t1, t2;
    for (int k = 0; k < 3; k++) begin
      @(posedge wclk); t0 = $realtime;
      @(negedge wclk); t1 = $realtime;
      @(posedge wclk); t2 = $realtime;
    end
    per = t2 - t0; hi = t1 - t0;
  endtask
  task automatic do_update();
    wr(4'h4, 32'h0); wr(4'h4, 32'h1);
  endtask

  initial begin
    #(150000.0 * P_BUS);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    real per, hi;
    int e0;
    void'($urandom(32'd4242));
    #22 rst_n = 1;
    repeat (40) @(negedge clk);

    // R1 reset values and stopped output
    rd(4'h0, d); chk_i(d == 0, "R1 sel", d, 0);
    rd(4'h4, d); chk_i(d == 0, "R1 upd", d, 0);
    rd(4'h8, d); chk_i(d == 0, "R1 div", d, 0);
    // R8 zero divider: no edges
    e0 = edges; #400;
    chk_i(edges == e0 && wclk == 0, "R8 off", edges - e0, 0);

    // R6 upper bits ignored, gap offset reads 0
    wr(4'h8, 32'hFFFF_FF01);
    rd(4'h8, d); chk_i(d == 32'h1, "R6 div", d, 1);
    rd(4'hC, d); chk_i(d == 0, "R6 gap", d, 0);
    wr(4'h0, 32'hFFFF_FFFD);
    rd(4'h0, d); chk_i(d == 32'h1, "R6 R2 sel", d, 1);

    // R10 pass-through of RC clock; R3 sel alone has no effect
    measure(per, hi);
    chk_r("R10 R3 period", per, P_IRC);
    chk_r("R10 high", hi, P_IRC / 2.0);

    // R4 + R7: switch to main, pending seen then cleared
    wr(4'h4, 32'h0);
    @(negedge clk); we = 1; addr = 4'h4; wdata = 32'h1;
    @(negedge clk); we = 0; re = 1;
    @(negedge clk); d = rdata; re = 0;
    chk_i(d == 32'h3, "R7 pending", d, 3);
    wait_switch();
    rd(4'h4, d); chk_i(d == 32'h1, "R7 clear", d, 1);
    measure(per, hi); chk_r("R4 main", per, P_MAIN);

    // R4 writing 1 while already 1 does nothing
    wr(4'h0, 32'h2); wr(4'h4, 32'h1);
    repeat (20) @(negedge clk);
    measure(per, hi); chk_r("R4 no rearm", per, P_MAIN);

    // R5 reserved code keeps source
    wr(4'h0, 32'h3); do_update();
    repeat (20) @(negedge clk);
    rd(4'h4, d); chk_i(d[1] == 0, "R5 no pending", d, 1);
    measure(per, hi); chk_r("R5 keep", per, P_MAIN);

    // R9 / R11 directed
    wr(4'h0, 32'h2); do_update(); wait_switch();
    wr(4'h8, 32'd5);
    measure(per, hi);
    chk_r("R9 R11 per5", per, 5.0 * P_WDO);
    chk_r("R9 hi5", hi, exp_high(2, 5));
    wr(4'h8, 32'd2);
    measure(per, hi);
    chk_r("R9 per2", per, 2.0 * P_WDO);
    chk_r("R9 hi2", hi, exp_high(2, 2));

    // R12 random switches and divisors
    for (int it = 0; it < 8; it++) begin
      int s, n;
      s = int'($urandom % 3);
      n = 1 + int'($urandom % 12);
      wr(4'h8, 32'(n));
      wr(4'h0, 32'(s)); do_update(); wait_switch();
      measure(per, hi);
      chk_r("R12 R9 rnd per", per, src_period(s) * real'(n));
      chk_r("R12 R9 rnd hi", hi, exp_high(s, n));
    end

    // R8 stop again
    wr(4'h8, 32'h0);
    repeat (60) @(negedge clk);
    e0 = edges; #500;
    chk_i(edges == e0 && wclk == 0, "R8 stop", edges - e0, 0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule